// File: doc/BRIEF.md
# Multi-Plane Hit Correlator

The block stores a binary hit image taken from a stack of detector planes. Each plane is a single-bit memory with one position per pixel, 1024 positions by default. A host writes fired pixels through a load port and can wipe the whole image in one cycle. For each correlation step the block reads every plane at its own address. It adds the fired bits into a vertical sum and compares that sum with a programmable threshold. The addresses follow a straight line: plane p is read at base + p·slope. The host supplies the base and the slope for each step.

In correlation mode the block counts steps from a run start. It latches the index of the first step whose total sum reaches the threshold, which is how the slope of a set of parallel tracks is found. In scan mode an extra offset is added to every address, and the host sweeps that offset across the memory while the slope stays fixed. Each rising crossing of the threshold counts as one track. Instances chain through a sum input and a sum output, so more than four planes can be covered. Only the last instance's threshold result is meaningful.

Top module: `hit_correlator`

## Requirements
- R1: After reset, `match`, `sum_valid`, `sum_hit` and `track_cnt` are 0, every memory bit is 0, and the step counter is 0.
- R2: A cycle with `wr_en` high stores `wr_bit` at position `wr_addr` of plane `wr_plane`. A later step that reads that position sees the stored value.
- R3: A cycle with `clr` high sets every bit of every plane to 0.
- R4: A step issued with `step_en` high in cycle k makes `cas_out` equal `cas_in` plus the number of planes p whose bit is 1 at address base_addr + p·slope (signed). This holds from the edge that ends cycle k until the next edge. `sum_valid` is 1 for one cycle after the following edge.
- R5: A plane address below 0 or above DEPTH−1 contributes 0. It never wraps to the other end of the memory.
- R6: `sum_hit` is 1 together with `sum_valid` exactly when the step's `cas_out` total is greater than or equal to `thr`. `thr` is sampled one edge after the step. A host normally sets `thr` to the total plane count minus a quantization allowance.
- R7: In correlation mode (`scan_mode` = 0), the first hitting step after `run_start` raises `match`, and `match_step` takes that step's 0-based index among the correlation steps since `run_start`. Both then hold until the next `run_start`.
- R8: In scan mode (`scan_mode` = 1), `scan_off` is added to every plane address. Scan steps neither advance the step index nor affect `match`.
- R9: In scan mode, `track_cnt` increases by one on each scan step that hits after a scan step that did not hit, or after `run_start`. A run of consecutive hitting scan steps counts once.
- R10: `run_start` clears `match`, `match_step`, `track_cnt`, the scan crossing state and the step index.
- R11: `cas_in` adds to the local plane count, so chained instances present their combined sum on the last `cas_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Wipe all plane memories |
| wr_en | input | 1 | Write one pixel |
| wr_plane | input | 2 | Plane selected for the write |
| wr_addr | input | 10 | Pixel position for the write |
| wr_bit | input | 1 | Value written |
| run_start | input | 1 | Restart step index, match and track count |
| step_en | input | 1 | Issue one correlation or scan step |
| scan_mode | input | 1 | 0 = correlation step, 1 = scan step |
| base_addr | input | 12 | Signed address for plane 0 |
| slope | input | 12 | Signed address increment per plane |
| scan_off | input | 12 | Signed offset added in scan mode |
| thr | input | 5 | Threshold for the total sum |
| cas_in | input | 5 | Sum from the previous instance |
| cas_out | output | 5 | Local count plus `cas_in` |
| sum_valid | output | 1 | Registered result of a step is present |
| sum_hit | output | 1 | That result reached `thr` |
| match | output | 1 | A correlation step has hit since `run_start` |
| match_step | output | 16 | Index of the first hitting correlation step |
| track_cnt | output | 8 | Rising threshold crossings in scan mode |

## Verification
The assertions assume several things about the host. Steps are not issued in the same cycle as `run_start`. `cas_in` and `thr` are held steady across a step's two-cycle window. The chained total never exceeds what `cas_out` can carry. The stimulus issues one step at a time, with idle cycles in between, and changes inputs only on the falling clock edge. Writes and clears are kept apart from steps, so a read never races a write to the same pixel. Negative bases and addresses past the top exercise the no-wrap rule. An image with two adjacent tracks exercises the counting of a single crossing.

// File: rtl/hit_correlator.sv
module hit_correlator #(
  parameter int PLANES     = 4,
  parameter int DEPTH      = 1024,
  parameter int MAX_PLANES = 16,
  parameter int STEP_W     = 16,
  parameter int TRK_W      = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = (PLANES > 1) ? $clog2(PLANES) : 1,
  localparam int SW = $clog2(MAX_PLANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_plane,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 wr_bit,
  input  logic                 run_start,
  input  logic                 step_en,
  input  logic                 scan_mode,
  input  logic signed [AW+1:0] base_addr,
  input  logic signed [AW+1:0] slope,
  input  logic signed [AW+1:0] scan_off,
  input  logic [SW-1:0]        thr,
  input  logic [SW-1:0]        cas_in,
  output logic [SW-1:0]        cas_out,
  output logic                 sum_valid,
  output logic                 sum_hit,
  output logic                 match,
  output logic [STEP_W-1:0]    match_step,
  output logic [TRK_W-1:0]     track_cnt
);

  localparam int XW = AW + 6;

  logic [DEPTH-1:0]         mem [PLANES];
  logic signed [XW-1:0]     offs;
  logic signed [XW-1:0]     pa [PLANES];
  logic [PLANES-1:0]        in_rng;
  logic [PLANES-1:0]        bits_q;
  logic [SW-1:0]            local_cnt;
  logic                     s1_valid, s1_scan;
  logic [STEP_W-1:0]        s1_idx, step_cnt;
  logic                     prev_hit;
  logic                     hit_now;

  assign offs = scan_mode ? XW'(scan_off) : XW'(0);

  for (genvar g = 0; g < PLANES; g++) begin : g_addr
    assign pa[g]     = XW'(base_addr) + XW'(slope) * XW'(g) + offs;
    assign in_rng[g] = (pa[g] >= 0) && (pa[g] < DEPTH);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       bits_q[g] <= 1'b0;
      else if (step_en) bits_q[g] <= in_rng[g] && mem[g][pa[g][AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PLANES; p++) mem[p] <= '0;
    end else if (clr) begin
      for (int p = 0; p < PLANES; p++) mem[p] <= '0;
    end else if (wr_en) begin
      mem[wr_plane][wr_addr] <= wr_bit;
    end
  end

  always_comb begin
    local_cnt = '0;
    for (int p = 0; p < PLANES; p++) local_cnt = local_cnt + SW'(bits_q[p]);
  end

  assign cas_out = cas_in + local_cnt;
  assign hit_now = cas_out >= thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_scan  <= 1'b0;
      s1_idx   <= '0;
      step_cnt <= '0;
    end else begin
      s1_valid <= step_en;
      if (step_en) begin
        s1_scan <= scan_mode;
        s1_idx  <= step_cnt;
      end
      if (run_start)                 step_cnt <= '0;
      else if (step_en && !scan_mode) step_cnt <= step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_valid  <= 1'b0;
      sum_hit    <= 1'b0;
      match      <= 1'b0;
      match_step <= '0;
      track_cnt  <= '0;
      prev_hit   <= 1'b0;
    end else begin
      sum_valid <= s1_valid;
      sum_hit   <= s1_valid && hit_now;
      if (run_start) begin
        match      <= 1'b0;
        match_step <= '0;
        track_cnt  <= '0;
        prev_hit   <= 1'b0;
      end else if (s1_valid) begin
        if (s1_scan) begin
          prev_hit <= hit_now;
          if (hit_now && !prev_hit) track_cnt <= track_cnt + 1'b1;
        end else if (hit_now && !match) begin
          match      <= 1'b1;
          match_step <= s1_idx;
        end
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ##1 sum_valid); // R4
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sum_hit |-> sum_valid); // R6
  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    match && !run_start |=> match); // R7
  AST_MATCH_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    match && !run_start |=> $stable(match_step)); // R7
  AST_TRACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> (track_cnt == $past(track_cnt)) || (track_cnt == $past(track_cnt) + 1'b1)); // R9

endmodule

// File: tb/test_hit_correlator.sv
module test_hit_correlator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, wr_en = 0, wr_bit = 0, run_start = 0, step_en = 0, scan_mode = 0;
  logic [1:0] wr_plane = '0;
  logic [9:0] wr_addr = '0;
  logic signed [11:0] base_addr = '0, slope = '0, scan_off = '0;
  logic [4:0] thr = 5'd15, cas_in = '0, cas_out;
  logic sum_valid, sum_hit, match;
  logic [15:0] match_step;
  logic [7:0] track_cnt;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  hit_correlator i_hit_correlator (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_plane(wr_plane),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .run_start(run_start), .step_en(step_en),
    .scan_mode(scan_mode), .base_addr(base_addr), .slope(slope), .scan_off(scan_off),
    .thr(thr), .cas_in(cas_in), .cas_out(cas_out), .sum_valid(sum_valid),
    .sum_hit(sum_hit), .match(match), .match_step(match_step), .track_cnt(track_cnt));

  localparam int NV = 8;
  localparam int VB [NV] = '{100, 100, 200, 500, 1021, -3, 100, 90};
  localparam int VS [NV] = '{3, 2, 3, 0, 1, 1, 3, 3};
  localparam int VM [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
  localparam int VO [NV] = '{0, 0, 0, 0, 0, 0, 0, 10};
  localparam int VC [NV] = '{0, 0, 0, 0, 0, 0, 5, 0};
  localparam int VE [NV] = '{4, 1, 4, 1, 2, 1, 9, 4};

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int p, input int a, input logic b);
    @(negedge clk);
    wr_en = 1; wr_plane = 2'(p); wr_addr = 10'(a); wr_bit = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); run_start = 1;
    @(negedge clk); run_start = 0;
  endtask

  // issues a step; returns cas_out one edge later, sum_hit two edges later
  task automatic step(input int b, input int s, input int m, input int o,
                      output int sum, output int hit);
    @(negedge clk);
    step_en = 1; base_addr = 12'(b); slope = 12'(s); scan_mode = m[0]; scan_off = 12'(o);
    @(negedge clk);
    step_en = 0;
    sum = int'(cas_out);
    @(negedge clk);
    hit = int'(sum_hit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int sm, ht;
    repeat (3) @(negedge clk);
    chk("R1 match", int'(match), 0);
    chk("R1 sum_valid", int'(sum_valid), 0);
    chk("R1 track_cnt", int'(track_cnt), 0);
    rst_n = 1;
    step(100, 3, 0, 0, sm, ht);
    chk("R1 empty memory", sm, 0);
    pulse_start();

    for (int p = 0; p < 4; p++) begin
      wr(p, 100 + 3 * p, 1'b1);
      wr(p, 200 + 3 * p, 1'b1);
    end
    wr(0, 500, 1'b1);
    wr(0, 1021, 1'b1);
    wr(2, 1023, 1'b1);
    wr(3, 0, 1'b1);

    // R4 R5 R8 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      cas_in = 5'(VC[i]);
      step(VB[i], VS[i], VM[i], VO[i], sm, ht);
      chk($sformatf("R4/R5/R8/R11 vector %0d", i), sm, VE[i]);
      cas_in = '0;
    end

    // R6 threshold boundary: base 1021 slope 1 sums to 2
    thr = 5'd2;
    step(1021, 1, 0, 0, sm, ht);
    chk("R6 hit at equal", ht, 1);
    thr = 5'd3;
    step(1021, 1, 0, 0, sm, ht);
    chk("R6 no hit below", ht, 0);

    // R7 R10 first match index
    thr = 5'd4;
    pulse_start();
    chk("R10 match cleared", int'(match), 0);
    step(100, 2, 0, 0, sm, ht);
    step(100, 1, 0, 0, sm, ht);
    chk("R7 no match yet", int'(match), 0);
    step(100, 3, 0, 0, sm, ht);
    chk("R7 match raised", int'(match), 1);
    chk("R7 match_step", int'(match_step), 2);
    step(200, 3, 0, 0, sm, ht);
    chk("R7 match_step held", int'(match_step), 2);

    // R8 R9 scan with adjacent tracks
    for (int p = 0; p < 4; p++) wr(p, 101 + 3 * p, 1'b1);
    pulse_start();
    chk("R10 match_step cleared", int'(match_step), 0);
    for (int o = 98; o <= 102; o++) step(0, 3, 1, o, sm, ht);
    chk("R9 adjacent offsets count once", int'(track_cnt), 1);
    for (int o = 198; o <= 202; o++) step(0, 3, 1, o, sm, ht);
    chk("R9 second track", int'(track_cnt), 2);
    chk("R8 scan leaves match low", int'(match), 0);
    step(100, 3, 0, 0, sm, ht);
    chk("R8 scan steps not indexed", int'(match_step), 0);
    chk("R8 correlation match after scan", int'(match), 1);
    pulse_start();
    chk("R10 track_cnt cleared", int'(track_cnt), 0);

    // R3 clear, R2 single writes
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    step(100, 3, 0, 0, sm, ht);
    chk("R3 cleared track", sm, 0);
    step(1021, 1, 0, 0, sm, ht);
    chk("R3 cleared edge pixels", sm, 0);
    wr(1, 7, 1'b1);
    step(7, 0, 0, 0, sm, ht);
    chk("R2 written bit read", sm, 1);
    wr(1, 7, 1'b0);
    step(7, 0, 0, 0, sm, ht);
    chk("R2 bit rewritten to zero", sm, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule